// File: doc/BRIEF.md
# Simultaneous-Sampling Conversion Sequencer

This block is the digital sequencing core of a multi-channel converter that samples every channel at the same instant and then delivers the results one at a time. Software stages an 8-bit channel-enable mask through a small parallel write port. A rising edge on the convert-start input freezes all channel values at once and adopts the staged mask as the mask for that run. A fixed cadence, counted on the block clock, then releases one result per enabled channel, from the lowest channel to the highest.

Each result is announced by a one-clock low pulse on the end-of-conversion strobe. The final result also pulls the end-of-last-conversion flag low, and the flag stays low until convert-start is dropped. Results are read through a 14-bit output port that drives only while both chip select and read strobe are low. The converted values themselves enter on a stimulus port. The block models only the timing and ordering of results, not how the values are produced.

Top module: `simsamp_seq`

## Requirements
- R1: After reset, eoc_n and eolc_n are 1, dout_en is 0, dout is 0, and the staged mask is all zeros.
- R2: The staged mask takes cfg_din on a clock edge that sees wr_n go from 0 to 1 while cs_n is 0. Bit i of the mask enables channel i (1 means on). A wr_n rising edge seen while cs_n is 1 leaves the mask unchanged.
- R3: A run uses the mask that was staged when its convert-start edge was detected. A write made during a run changes only the next run.
- R4: All channel values are captured on the clock edge that detects cnvst rising. Changes on chan_values after that edge do not alter the results of that run.
- R5: The first result appears on the 16th clock edge after the start-detect edge. eoc_n is low for exactly one clock per result.
- R6: Each further result follows 3 clocks after the previous one. Results come in ascending channel order and skip disabled channels, so with N enabled channels the last result arrives at edge 16+3(N-1).
- R7: eolc_n goes low on the same edge as the last result's eoc_n pulse. It stays low until the edge that sees cnvst fall.
- R8: If the mask is zero at a start, no eoc_n pulse occurs, and eolc_n is low for exactly one clock, set by the start-detect edge.
- R9: While cs_n and rd_n are both 0, dout_en is 1 and dout shows the most recent result. Otherwise dout_en is 0 and dout is 0.
- R10: While pwr_down is 1, cnvst rising edges start nothing. The staged mask survives a power-down period unchanged.
- R11: A cnvst fall or rise during a run is ignored, and the run completes normally.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Conversion clock; every edge count refers to it |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low |
| wr_n | input | 1 | Write strobe; its rising edge stages the mask |
| cfg_din | input | 8 | Channel-enable word, bit i for channel i |
| cnvst | input | 1 | Convert start; its rising edge samples and launches a run |
| pwr_down | input | 1 | Power-down request; blocks new runs |
| rd_n | input | 1 | Read strobe, active low |
| chan_values | input | 112 | Stimulus values, channel i at bits [14i+13:14i] |
| eoc_n | output | 1 | One-clock low pulse per available result |
| eolc_n | output | 1 | Low once the final result of a run is available |
| dout | output | 14 | Result bus, zero when not driven |
| dout_en | output | 1 | High while the result bus is driven |

## Verification
The assertions assume that convert-start is held high until the final result has been produced, except in the one test that deliberately toggles it during a run. They also assume reset lasts at least two clocks and that the write strobe stays high when idle. The bench changes every input at the falling clock edge. It drops convert-start only after the last expected result, or in the single mid-run glitch case that R11 covers. This keeps the timing relations on eoc_n and eolc_n valid for all other stimulus.

// File: rtl/simsamp_pkg.sv
package simsamp_pkg;

    localparam int unsigned NCH_DEF       = 8;
    localparam int unsigned RES_W_DEF     = 14;
    localparam int unsigned FIRST_LAT_DEF = 16;
    localparam int unsigned STEP_DEF      = 3;

    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,
        SEQ_RUN  = 2'd1,
        SEQ_ZERO = 2'd2
    } seq_mode_e;

    typedef struct packed {
        logic rise;
        logic fall;
    } edge_t;

    // index of the lowest set bit, 0 when none is set
    function automatic int unsigned lowest_set(input logic [31:0] m);
        int unsigned idx;
        idx = 0;
        for (int i = 31; i >= 0; i--) begin
            if (m[i]) idx = i;
        end
        return idx;
    endfunction

endpackage

// File: rtl/simsamp_edge.sv
module simsamp_edge #(
    parameter logic RST_VAL = 1'b1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 sig,
    output simsamp_pkg::edge_t   edges
);
    logic prev_q;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= RST_VAL;
        else     prev_q <= sig;
    end

    always_comb begin
        edges.rise = sig & ~prev_q;
        edges.fall = ~sig & prev_q;
    end
endmodule

// File: rtl/simsamp_cfg.sv
module simsamp_cfg #(
    parameter int unsigned NCH = 8
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           cs_n,
    input  logic           wr_n,
    input  logic [NCH-1:0] cfg_din,
    output logic [NCH-1:0] staged
);
    logic wr_prev_q;
    logic take;

    assign take = wr_n & ~wr_prev_q & ~cs_n;

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_prev_q <= 1'b1;
            staged    <= '0;
        end else begin
            wr_prev_q <= wr_n;
            if (take) staged <= cfg_din;
        end
    end
endmodule

// File: rtl/simsamp_core.sv
module simsamp_core
    import simsamp_pkg::*;
#(
    parameter int unsigned NCH       = 8,
    parameter int unsigned RES_W     = 14,
    parameter int unsigned FIRST_LAT = 16,
    parameter int unsigned STEP      = 3
) (
    input  logic               clk,
    input  logic               rst,
    input  edge_t              start_edges,
    input  logic               pwr_down,
    input  logic [NCH-1:0]     staged,
    input  logic [NCH*RES_W-1:0] chan_values,
    output logic [NCH-1:0]     run_mask,
    output logic [RES_W-1:0]   result,
    output logic               eoc_n,
    output logic               eolc_n
);
    localparam int unsigned CNT_W = $clog2(FIRST_LAT + 1);
    localparam int unsigned CH_W  = (NCH > 1) ? $clog2(NCH) : 1;
    localparam logic [CNT_W-1:0] FIRST_LOAD = CNT_W'(FIRST_LAT - 1);
    localparam logic [CNT_W-1:0] STEP_LOAD  = CNT_W'(STEP - 1);

    logic [RES_W-1:0] in_vals [NCH];
    logic [RES_W-1:0] hold_q  [NCH];
    seq_mode_e        mode_q;
    logic [CNT_W-1:0] wait_q;
    logic [NCH-1:0]   remain_q;
    logic [CH_W-1:0]  pick;
    logic [NCH-1:0]   remain_nxt;
    logic             go;

    for (genvar g = 0; g < NCH; g++) begin : g_unpack
        assign in_vals[g] = chan_values[g*RES_W +: RES_W];
    end

    assign go         = start_edges.rise & ~pwr_down & (mode_q != SEQ_RUN);
    assign pick       = CH_W'(lowest_set(32'(remain_q)));
    assign remain_nxt = remain_q & ~(NCH'(1) << pick);

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q   <= SEQ_IDLE;
            wait_q   <= '0;
            remain_q <= '0;
            run_mask <= '0;
            result   <= '0;
            eoc_n    <= 1'b1;
            eolc_n   <= 1'b1;
            for (int i = 0; i < NCH; i++) hold_q[i] <= '0;
        end else begin
            eoc_n <= 1'b1;
            if (go) begin
                run_mask <= staged;
                remain_q <= staged;
                for (int i = 0; i < NCH; i++) hold_q[i] <= in_vals[i];
                if (staged == '0) begin
                    mode_q <= SEQ_ZERO;
                    eolc_n <= 1'b0;
                end else begin
                    mode_q <= SEQ_RUN;
                    wait_q <= FIRST_LOAD;
                    eolc_n <= 1'b1;
                end
            end else begin
                case (mode_q)
                    SEQ_RUN: begin
                        if (wait_q == '0) begin
                            result   <= hold_q[pick];
                            eoc_n    <= 1'b0;
                            remain_q <= remain_nxt;
                            if (remain_nxt == '0) begin
                                mode_q <= SEQ_IDLE;
                                eolc_n <= 1'b0;
                            end else begin
                                wait_q <= STEP_LOAD;
                            end
                        end else begin
                            wait_q <= wait_q - 1'b1;
                        end
                    end
                    SEQ_ZERO: begin
                        mode_q <= SEQ_IDLE;
                        eolc_n <= 1'b1;
                    end
                    default: begin
                        if (start_edges.fall) eolc_n <= 1'b1;
                    end
                endcase
            end
        end
    end
endmodule

// File: rtl/simsamp_rdport.sv
module simsamp_rdport #(
    parameter int unsigned RES_W = 14
) (
    input  logic             cs_n,
    input  logic             rd_n,
    input  logic [RES_W-1:0] result,
    output logic [RES_W-1:0] dout,
    output logic             dout_en
);
    always_comb begin
        dout_en = ~cs_n & ~rd_n;
        dout    = dout_en ? result : '0;
    end
endmodule

// File: rtl/simsamp_seq.sv
module simsamp_seq (
    input  logic          clk,
    input  logic          rst,
    input  logic          cs_n,
    input  logic          wr_n,
    input  logic [7:0]    cfg_din,
    input  logic          cnvst,
    input  logic          pwr_down,
    input  logic          rd_n,
    input  logic [111:0]  chan_values,
    output logic          eoc_n,
    output logic          eolc_n,
    output logic [13:0]   dout,
    output logic          dout_en
);
    import simsamp_pkg::*;

    localparam int unsigned NCH   = NCH_DEF;
    localparam int unsigned RES_W = RES_W_DEF;

    edge_t            start_edges;
    logic [NCH-1:0]   staged_mask;
    logic [NCH-1:0]   run_mask;
    logic [RES_W-1:0] result;

    simsamp_edge #(.RST_VAL(1'b1)) u_cnv_edge (
        .clk   (clk),
        .rst   (rst),
        .sig   (cnvst),
        .edges (start_edges)
    );

    simsamp_cfg #(.NCH(NCH)) u_cfg (
        .clk     (clk),
        .rst     (rst),
        .cs_n    (cs_n),
        .wr_n    (wr_n),
        .cfg_din (cfg_din),
        .staged  (staged_mask)
    );

    simsamp_core #(
        .NCH       (NCH),
        .RES_W     (RES_W),
        .FIRST_LAT (FIRST_LAT_DEF),
        .STEP      (STEP_DEF)
    ) u_core (
        .clk         (clk),
        .rst         (rst),
        .start_edges (start_edges),
        .pwr_down    (pwr_down),
        .staged      (staged_mask),
        .chan_values (chan_values),
        .run_mask    (run_mask),
        .result      (result),
        .eoc_n       (eoc_n),
        .eolc_n      (eolc_n)
    );

    simsamp_rdport #(.RES_W(RES_W)) u_rd (
        .cs_n    (cs_n),
        .rd_n    (rd_n),
        .result  (result),
        .dout    (dout),
        .dout_en (dout_en)
    );
endmodule

// File: rtl/simsamp_seq_chk.sv
module simsamp_seq_chk #(
    parameter int unsigned NCH = 8
) (
    input logic           clk,
    input logic           rst,
    input logic           cs_n,
    input logic           wr_n,
    input logic           cnvst,
    input logic           eoc_n,
    input logic           eolc_n,
    input logic [NCH-1:0] staged_mask,
    input logic [NCH-1:0] run_mask,
    input logic           start_rise
);
    // R5: each result strobe lasts a single clock
    p_eoc_single_r5: assert property (@(posedge clk) disable iff (rst)
        !eoc_n |=> eoc_n);

    // R6: strobes are at least three clocks apart
    p_eoc_gap_r6: assert property (@(posedge clk) disable iff (rst)
        $fell(eoc_n) |-> $past(eoc_n, 2));

    // R7, R8: last flag falls with a result strobe or on a start edge
    p_eolc_fall_r7: assert property (@(posedge clk) disable iff (rst)
        $fell(eolc_n) |-> (!eoc_n || ($past(cnvst) && !$past(cnvst, 2))));

    // R7: last flag releases on a convert-start fall, a new start, or after a one-clock pulse
    p_eolc_release_r7: assert property (@(posedge clk) disable iff (rst)
        $rose(eolc_n) |-> (!$past(cnvst) || $past(eolc_n, 2)
                           || ($past(cnvst) && !$past(cnvst, 2))));

    // R3: the run mask changes only after a start edge
    p_run_mask_r3: assert property (@(posedge clk) disable iff (rst)
        (run_mask != $past(run_mask)) |-> $past(start_rise));

    // R2, R10: staged mask changes only after a selected write strobe rise
    p_stage_write_r2: assert property (@(posedge clk) disable iff (rst)
        (staged_mask != $past(staged_mask)) |->
            ($past(!cs_n) && $past(wr_n) && !$past(wr_n, 2)));
endmodule

bind simsamp_seq simsamp_seq_chk #(.NCH(NCH)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .cs_n        (cs_n),
    .wr_n        (wr_n),
    .cnvst       (cnvst),
    .eoc_n       (eoc_n),
    .eolc_n      (eolc_n),
    .staged_mask (staged_mask),
    .run_mask    (run_mask),
    .start_rise  (start_edges.rise)
);

// File: tb/simsamp_seq_tb.sv
module simsamp_seq_tb;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         cs_n = 1'b1;
    logic         wr_n = 1'b1;
    logic [7:0]   cfg_din = '0;
    logic         cnvst = 1'b0;
    logic         pwr_down = 1'b0;
    logic         rd_n = 1'b1;
    logic [111:0] chan_values = '0;
    logic         eoc_n;
    logic         eolc_n;
    logic [13:0]  dout;
    logic         dout_en;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    simsamp_seq u_dut (
        .clk (clk), .rst (rst), .cs_n (cs_n), .wr_n (wr_n),
        .cfg_din (cfg_din), .cnvst (cnvst), .pwr_down (pwr_down),
        .rd_n (rd_n), .chan_values (chan_values), .eoc_n (eoc_n),
        .eolc_n (eolc_n), .dout (dout), .dout_en (dout_en)
    );

    typedef struct packed {
        logic [7:0]  mask;
        logic [13:0] seed;
        logic        glitch;
    } vec_t;

    localparam int NV = 6;
    localparam vec_t VECS [NV] = '{
        '{8'h01, 14'h0123, 1'b0},
        '{8'h80, 14'h3A5C, 1'b0},
        '{8'hFF, 14'h1111, 1'b0},
        '{8'hA5, 14'h2F0E, 1'b0},
        '{8'h03, 14'h0777, 1'b1},
        '{8'h4C, 14'h3FFF, 1'b0}
    };

    function automatic logic [13:0] expv(input int ch, input logic [13:0] seed);
        return seed + 14'(ch * 2339);
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic write_cfg(input logic [7:0] val, input logic cs_val);
        @(negedge clk);
        cs_n = cs_val; cfg_din = val; wr_n = 1'b0;
        @(negedge clk);
        wr_n = 1'b1;
        @(negedge clk);
        cs_n = 1'b1;
    endtask

    // m is the mask the run is expected to use
    task automatic run_conv(input logic [7:0] m, input logic [13:0] seed,
                            input bit glitch, input bit midwr, input logic [7:0] midval);
        int n;
        int last;
        int limit;
        int nxt;
        bit exp_eoc;
        bit exp_eolc;
        n = $countones(m);
        last = 16 + 3 * (n - 1);
        limit = (n == 0) ? 3 : last + 3;
        nxt = 0;
        @(negedge clk);
        for (int c = 0; c < 8; c++) chan_values[c*14 +: 14] = expv(c, seed);
        cnvst = 1'b1;
        for (int k = 0; k <= limit; k++) begin
            @(posedge clk);
            @(negedge clk);
            if (k == 1) chan_values = ~chan_values;          // R4 disturbance
            if (glitch && k == 5) cnvst = 1'b0;              // R11
            if (glitch && k == 8) cnvst = 1'b1;              // R11
            if (midwr && k == 3) begin cs_n = 1'b0; wr_n = 1'b0; cfg_din = midval; end
            if (midwr && k == 4) wr_n = 1'b1;
            if (midwr && k == 5) cs_n = 1'b1;
            exp_eoc = (n > 0) && (k >= 16) && ((k - 16) % 3 == 0) && ((k - 16) / 3 < n);
            exp_eolc = (n == 0) ? (k == 0) : (k >= last);
            chk(eoc_n == !exp_eoc, "R5/R6 eoc_n", int'(eoc_n), int'(!exp_eoc));
            chk(eolc_n == !exp_eolc, "R7/R8 eolc_n", int'(eolc_n), int'(!exp_eolc));
            if (exp_eoc) begin
                while (nxt < 8 && !m[nxt]) nxt++;
                cs_n = 1'b0; rd_n = 1'b0;
                #1;
                chk(dout_en == 1'b1, "R9 dout_en", int'(dout_en), 1);
                chk(dout == expv(nxt, seed), "R4/R6 dout", int'(dout), int'(expv(nxt, seed)));
                rd_n = 1'b1; cs_n = 1'b1;
                nxt++;
            end
        end
        @(negedge clk);
        cnvst = 1'b0;
        @(posedge clk);
        @(negedge clk);
        chk(eolc_n == 1'b1, "R7 release", int'(eolc_n), 1);
        chk(eoc_n == 1'b1, "R6 no extra eoc", int'(eoc_n), 1);
    endtask

    initial begin
        #(4 * 150000);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual running expected done");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        // R1: reset state
        chk(eoc_n == 1'b1, "R1 eoc_n", int'(eoc_n), 1);
        chk(eolc_n == 1'b1, "R1 eolc_n", int'(eolc_n), 1);
        chk(dout_en == 1'b0, "R1 dout_en", int'(dout_en), 0);
        chk(dout == 14'd0, "R1 dout", int'(dout), 0);
        rst = 1'b0;
        repeat (2) @(negedge clk);
        // R1, R8: never-written mask is zero
        run_conv(8'h00, 14'h0001, 1'b0, 1'b0, 8'h00);

        // vector table walk (R2, R4, R5, R6, R7, R11)
        for (int v = 0; v < NV; v++) begin
            write_cfg(VECS[v].mask, 1'b0);
            run_conv(VECS[v].mask, VECS[v].seed, VECS[v].glitch, 1'b0, 8'h00);
        end

        // R2: write with cs_n high is ignored; mask stays 4C
        write_cfg(8'h0F, 1'b1);
        run_conv(8'h4C, 14'h0200, 1'b0, 1'b0, 8'h00);

        // R3: write during a run affects only the next run
        write_cfg(8'h03, 1'b0);
        run_conv(8'h03, 14'h1234, 1'b0, 1'b1, 8'h0C);
        run_conv(8'h0C, 14'h0456, 1'b0, 1'b0, 8'h00);

        // R8: explicit zero mask
        write_cfg(8'h00, 1'b0);
        run_conv(8'h00, 14'h0000, 1'b0, 1'b0, 8'h00);
        write_cfg(8'h0C, 1'b0);

        // R10: starts ignored while powered down, mask kept
        @(negedge clk);
        pwr_down = 1'b1;
        @(negedge clk);
        cnvst = 1'b1;
        for (int k = 0; k < 25; k++) begin
            @(negedge clk);
            chk(eoc_n == 1'b1, "R10 eoc_n", int'(eoc_n), 1);
            chk(eolc_n == 1'b1, "R10 eolc_n", int'(eolc_n), 1);
        end
        cnvst = 1'b0;
        @(negedge clk);
        pwr_down = 1'b0;
        run_conv(8'h0C, 14'h2222, 1'b0, 1'b0, 8'h00);

        // R9: read strobe without chip select leaves the bus undriven
        @(negedge clk);
        cs_n = 1'b1; rd_n = 1'b0;
        #1;
        chk(dout_en == 1'b0, "R9 cs high dout_en", int'(dout_en), 0);
        chk(dout == 14'd0, "R9 cs high dout", int'(dout), 0);
        rd_n = 1'b1;

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule